// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Generator

This block drives an eight-digit, seven-segment LED display one digit at a time. It reads each digit's word from an external display RAM, decodes it, and drives one digit-enable line together with eight segment lines: a to g and the decimal point. A short dark gap separates consecutive digits, so that the segment pattern of one digit never shows on its neighbour. Digits are visited in a fixed interleaved order, not in numerical order.

Each RAM word carries a per-digit flag that selects raw segment control. When the flag is clear, the low nibble is shown either as a hexadecimal glyph or as a Code B glyph; a global input chooses between the two. The dwell time and the gap time are given in microseconds and converted to clock cycles from the clock frequency parameter. A parameter sets the output polarity for common-anode or common-cathode displays.

A shutdown input stops the scan and darkens the display. A blank input darkens the display while the scan keeps running. The RAM is read asynchronously: the block presents an address and uses the returned word in the same cycle.

Top module: `seg_scan_mux`

## Requirements
- R1: Digits are lit in the repeating order 2, 5, 1, 7, 8, 6, 4, 3. Digit n is `dig_o` bit n-1, and the first digit lit after reset is digit 2.
- R2: Each digit stays lit for exactly DWELL_CYC = CLK_HZ/1000*DWELL_US/1000 consecutive cycles (minimum 1).
- R3: Between two digits, all digit and segment outputs are off for exactly GAP_CYC = CLK_HZ/1000*GAP_US/1000 cycles (minimum 1). One digit never changes directly into another, and no segment is lit while no digit is lit.
- R4: At most one digit output is active in any cycle.
- R5: In decode mode with `hex_sel_i`=1, the low nibble 0..15 shows the glyphs 0-9 and A, b, C, d, E, F.
- R6: In decode mode with `hex_sel_i`=0 (Code B), codes 0..9 show digits, and 10..15 show "-", E, H, L, P and blank.
- R7: When the RAM raw flag is 1, each word bit lights one segment: bit6 a, bit5 b, bit4 c, bit3 e, bit2 g, bit1 f, bit0 d. `seg_o` bits 0..6 are segments a..g and bit 7 is the decimal point.
- R8: In every mode, word bit 7 lights the decimal point when it is 0. As a result, 0xFF in Code B and 0x80 in raw mode both show a dark digit.
- R9: While `shutdown_i` is 1, all outputs are off from the next cycle on and the scan timebase is frozen. After release, the scan resumes at the slot where it stopped.
- R10: While `blank_i` is 1, all outputs are off from the next cycle on, but the scan keeps advancing.
- R11: With COMMON_ANODE=1, digit outputs are active high and segment outputs active low. With COMMON_ANODE=0, both are inverted. During reset and in the cycle after it, all drivers are off.
- R12: The RAM address is {`bank_sel_i`, digit number minus 1}. The word and raw flag returned for that address determine the lit segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown_i | input | 1 | Stop scan and darken display |
| blank_i | input | 1 | Darken display, scan continues |
| hex_sel_i | input | 1 | 1 hexadecimal glyphs, 0 Code B glyphs |
| bank_sel_i | input | 1 | RAM bank, upper address bit |
| ram_addr_o | output | 4 | Display RAM read address |
| ram_data_i | input | 8 | Digit word from RAM |
| ram_raw_i | input | 1 | Per-digit raw segment flag from RAM |
| dig_o | output | 8 | Digit enables, bit n-1 is digit n |
| seg_o | output | 8 | Segments a..g in bits 0..6, decimal point in bit 7 |

## Verification
On every cycle, the assertions check that at most one digit is lit, that one digit never hands over directly to another, that segments are dark whenever no digit is lit, and that shutdown, blank and reset darken the outputs one cycle later. The scenarios are what show the scan order, the exact dwell and gap lengths, every hexadecimal, Code B and raw glyph, the bank addressing, and the polarity pair. They also show whether the scan resumes in place after shutdown but moves on during blank, which only a comparison across many cycles can reveal.

// File: rtl/seg_scan_mux.sv
module seg_scan_mux #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int DWELL_US     = 320,
  parameter int GAP_US       = 10,
  parameter bit COMMON_ANODE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shutdown_i,
  input  logic       blank_i,
  input  logic       hex_sel_i,
  input  logic       bank_sel_i,
  output logic [3:0] ram_addr_o,
  input  logic [7:0] ram_data_i,
  input  logic       ram_raw_i,
  output logic [7:0] dig_o,
  output logic [7:0] seg_o
);

  localparam int DWELL_RAW = ((CLK_HZ / 1000) * DWELL_US) / 1000;
  localparam int GAP_RAW   = ((CLK_HZ / 1000) * GAP_US) / 1000;
  localparam int DWELL_CYC = (DWELL_RAW < 1) ? 1 : DWELL_RAW;
  localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CNT_MAX   = (DWELL_CYC > GAP_CYC) ? DWELL_CYC : GAP_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic             on_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       slot_q;
  logic [2:0]       dig_idx;
  logic             last;
  logic             show;
  logic [6:0]       shape;
  logic [7:0]       lit;
  logic [7:0]       dig_q;
  logic [7:0]       seg_q;

  function automatic logic [6:0] glyph(input logic [3:0] c, input logic hex);
    logic [6:0] g;
    case (c)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = hex ? 7'h77 : 7'h40;
      4'hB: g = hex ? 7'h7C : 7'h79;
      4'hC: g = hex ? 7'h39 : 7'h76;
      4'hD: g = hex ? 7'h5E : 7'h38;
      4'hE: g = hex ? 7'h79 : 7'h73;
      default: g = hex ? 7'h71 : 7'h00;
    endcase
    return g;
  endfunction

  always_comb begin
    case (slot_q)
      3'd0: dig_idx = 3'd1;
      3'd1: dig_idx = 3'd4;
      3'd2: dig_idx = 3'd0;
      3'd3: dig_idx = 3'd6;
      3'd4: dig_idx = 3'd7;
      3'd5: dig_idx = 3'd5;
      3'd6: dig_idx = 3'd3;
      default: dig_idx = 3'd2;
    endcase
  end

  assign ram_addr_o = {bank_sel_i, dig_idx};

  assign last = on_q ? (cnt_q == CNT_W'(DWELL_CYC - 1))
                     : (cnt_q == CNT_W'(GAP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (!shutdown_i) begin
      if (last) begin
        cnt_q <= '0;
        on_q  <= ~on_q;
        if (on_q) slot_q <= slot_q + 3'd1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign shape = ram_raw_i ? {ram_data_i[2], ram_data_i[1], ram_data_i[3], ram_data_i[0],
                              ram_data_i[4], ram_data_i[5], ram_data_i[6]}
                           : glyph(ram_data_i[3:0], hex_sel_i);
  assign lit  = {~ram_data_i[7], shape};
  assign show = on_q & ~shutdown_i & ~blank_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      seg_q <= '0;
    end else begin
      dig_q <= show ? (8'd1 << dig_idx) : 8'd0;
      seg_q <= show ? lit : 8'd0;
    end
  end

  generate
    if (COMMON_ANODE) begin : g_anode
      assign dig_o = dig_q;
      assign seg_o = ~seg_q;
    end else begin : g_cathode
      assign dig_o = ~dig_q;
      assign seg_o = seg_q;
    end
  endgenerate

endmodule

// File: rtl/seg_scan_mux_chk.sv
module seg_scan_mux_chk #(
  parameter bit COMMON_ANODE = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       shutdown_i,
  input logic       blank_i,
  input logic [7:0] dig_o,
  input logic [7:0] seg_o
);

  logic [7:0] dig_on;
  logic [7:0] seg_on;
  assign dig_on = COMMON_ANODE ? dig_o : ~dig_o;
  assign seg_on = COMMON_ANODE ? ~seg_o : seg_o;

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dig_on)); // R4
  AST_NO_DIRECT_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    dig_on != 8'd0 |=> (dig_on == 8'd0 || $stable(dig_on))); // R3
  AST_SEG_DARK_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    dig_on == 8'd0 |-> seg_on == 8'd0); // R3
  AST_SHUTDOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (dig_on == 8'd0 && seg_on == 8'd0)); // R9
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> (dig_on == 8'd0 && seg_on == 8'd0)); // R10
  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |=> (dig_on == 8'd0 && seg_on == 8'd0)); // R11

endmodule

bind seg_scan_mux seg_scan_mux_chk #(.COMMON_ANODE(COMMON_ANODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown_i), .blank_i(blank_i),
  .dig_o(dig_o), .seg_o(seg_o)
);

// File: tb/seg_scan_mux_tb_top.sv
module seg_scan_mux_tb_top;
  localparam int DW = 64;
  localparam int GW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn = 1'b0, blank = 1'b0, hex_sel = 1'b1, bank_sel = 1'b0;
  logic [3:0] addr_a, addr_c;
  logic [7:0] dig_a, seg_a, dig_c, seg_c;
  logic [7:0] mem [16];
  logic       rawm [16];
  int n_tests = 0, n_fail = 0;
  int pos = 0;
  bit done = 0;
  int ord [8] = '{1, 4, 0, 6, 7, 5, 3, 2};
  bit gap_bad, hot_bad, pol_bad, seg_unstable;

  always #4 clk = ~clk;

  seg_scan_mux #(.CLK_HZ(200_000), .COMMON_ANODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .shutdown_i(shdn), .blank_i(blank), .hex_sel_i(hex_sel),
    .bank_sel_i(bank_sel), .ram_addr_o(addr_a), .ram_data_i(mem[addr_a]),
    .ram_raw_i(rawm[addr_a]), .dig_o(dig_a), .seg_o(seg_a));

  seg_scan_mux #(.CLK_HZ(200_000), .COMMON_ANODE(1'b0)) dut_cc (
    .clk(clk), .rst_n(rst_n), .shutdown_i(shdn), .blank_i(blank), .hex_sel_i(hex_sel),
    .bank_sel_i(bank_sel), .ram_addr_o(addr_c), .ram_data_i(mem[addr_c]),
    .ram_raw_i(rawm[addr_c]), .dig_o(dig_c), .seg_o(seg_c));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lit(input logic [7:0] w, input logic raw, input logic hex);
    logic [6:0] s;
    if (raw) begin
      s = '0;
      s[0] = w[6]; s[1] = w[5]; s[2] = w[4]; s[4] = w[3];
      s[6] = w[2]; s[5] = w[1]; s[3] = w[0];
    end else begin
      case (w[3:0])
        0: s = 7'b0111111;  1: s = 7'b0000110;  2: s = 7'b1011011;  3: s = 7'b1001111;
        4: s = 7'b1100110;  5: s = 7'b1101101;  6: s = 7'b1111101;  7: s = 7'b0000111;
        8: s = 7'b1111111;  9: s = 7'b1101111;
        10: s = hex ? 7'b1110111 : 7'b1000000;
        11: s = hex ? 7'b1111100 : 7'b1111001;
        12: s = hex ? 7'b0111001 : 7'b1110110;
        13: s = hex ? 7'b1011110 : 7'b0111000;
        14: s = hex ? 7'b1111001 : 7'b1110011;
        default: s = hex ? 7'b1110001 : 7'b0000000;
      endcase
    end
    return {~w[7], s};
  endfunction

  task automatic next_pulse(output int idx, output int len, output int gap, output logic [7:0] lit);
    gap = 0; len = 0; idx = -1; lit = 0;
    while (dig_a == 8'd0) begin
      if (seg_a != 8'hFF) gap_bad = 1;
      if (dig_c !== ~dig_a || seg_c !== ~seg_a) pol_bad = 1;
      gap++;
      @(negedge clk);
    end
    lit = ~seg_a;
    for (int i = 0; i < 8; i++) if (dig_a[i]) idx = i;
    while (dig_a != 8'd0) begin
      if ($countones(dig_a) != 1) hot_bad = 1;
      if (~seg_a != lit) seg_unstable = 1;
      if (dig_c !== ~dig_a || seg_c !== ~seg_a) pol_bad = 1;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input string req, input bit skip_first_gap);
    int idx, len, gap;
    logic [7:0] lit, e;
    for (int k = 0; k < 8; k++) begin
      gap_bad = 0; hot_bad = 0; pol_bad = 0; seg_unstable = 0;
      next_pulse(idx, len, gap, lit);
      chk(idx == ord[pos], "R1 scan order", idx, ord[pos]);
      chk(len == DW, "R2 dwell length", len, DW);
      if (!(skip_first_gap && k == 0)) chk(gap == GW, "R3 gap length", gap, GW);
      chk(!gap_bad && !hot_bad && !seg_unstable, "R3 R4 dark gap and single digit", 1, 0);
      chk(!pol_bad, "R11 polarity pair", 1, 0);
      e = exp_lit(mem[{bank_sel, 3'(ord[pos])}], rawm[{bank_sel, 3'(ord[pos])}], hex_sel);
      chk(lit == e, req, lit, e);
      pos = (pos + 1) % 8;
    end
  endtask

  task automatic fill(input int bank, input int base, input bit raw, input bit dp_even);
    for (int d = 0; d < 8; d++) begin
      mem[bank*8 + d]  = {(dp_even && d % 2 == 0) ? 1'b0 : 1'b1, 3'b000, 4'(base + d)};
      rawm[bank*8 + d] = raw;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int idx, len, gap;
    logic [7:0] lit;
    bit dark;
    for (int i = 0; i < 16; i++) begin mem[i] = 8'hFF; rawm[i] = 1'b0; end
    fill(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(dig_a == 8'h00 && seg_a == 8'hFF, "R11 reset anode off", {dig_a, seg_a}, 16'h00FF);
    chk(dig_c == 8'hFF && seg_c == 8'h00, "R11 reset cathode off", {dig_c, seg_c}, 16'hFF00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dig_a == 8'h00 && seg_a == 8'hFF, "R11 off after reset", {dig_a, seg_a}, 16'h00FF);

    run_frame("R5 hex 0-7", 1);
    fill(0, 8, 0, 1);
    run_frame("R5 R8 hex 8-F with dp", 0);
    hex_sel = 1'b0; fill(0, 0, 0, 1);
    run_frame("R6 code B 0-7", 0);
    fill(0, 8, 0, 0);
    run_frame("R6 code B 10-15", 0);
    hex_sel = 1'b1;
    for (int d = 0; d < 8; d++) begin
      mem[d] = (d < 7) ? (8'h80 | (8'd1 << d)) : 8'h00; rawm[d] = 1'b1;
    end
    run_frame("R7 raw single bits", 0);
    for (int d = 0; d < 8; d++) begin mem[d] = 8'h80; rawm[d] = 1'b1; end
    run_frame("R8 raw 0x80 dark", 0);
    hex_sel = 1'b0;
    for (int d = 0; d < 8; d++) begin mem[d] = 8'hFF; rawm[d] = 1'b0; end
    run_frame("R8 code B 0xFF dark", 0);
    bank_sel = 1'b1; hex_sel = 1'b1;
    for (int d = 0; d < 8; d++) begin
      mem[8 + d] = 8'(8'h35 + d * 8'h13); rawm[8 + d] = d[0];
    end
    run_frame("R12 bank 1 mixed raw", 0);

    blank = 1'b1; dark = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (dig_a != 8'h00 || seg_a != 8'hFF) dark = 0;
    end
    blank = 1'b0;
    chk(dark, "R10 blank darkens", dark, 1);
    next_pulse(idx, len, gap, lit);
    chk(idx == ord[(pos + 1) % 8], "R10 scan advanced under blank", idx, ord[(pos + 1) % 8]);
    chk(len < DW, "R10 partial digit after blank", len, DW - 1);
    pos = (pos + 2) % 8;

    shdn = 1'b1; dark = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (dig_a != 8'h00 || seg_a != 8'hFF || dig_c != 8'hFF || seg_c != 8'h00) dark = 0;
    end
    shdn = 1'b0;
    chk(dark, "R9 shutdown darkens", dark, 1);
    next_pulse(idx, len, gap, lit);
    chk(idx == ord[pos], "R9 scan resumes in place", idx, ord[pos]);
    chk(len == DW, "R9 full dwell after release", len, DW);
    pos = (pos + 1) % 8;
    run_frame("R12 bank 1 after shutdown", 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule